// File: doc/BRIEF.md
# Trap Entry Sequencer

This block performs the entry half of trap handling in a small 32-bit soft processor. Each cycle it looks at up to four trap requests: an external interrupt, a hardware break, a hardware exception (which includes misaligned data accesses) and a memory-translation fault. It picks at most one of them, accepts it or drops it, and computes everything the core must commit when it enters the handler. That covers the new fetch address, which link register gets the return address and what that address is, the rewritten machine status word, and the exception syndrome, fault address and saved branch-target registers.

The pipeline supplies the current PC, the status word, the per-instruction context flags (branch delay slot, immediate prefix, prefixed branch), the pending branch target and the base vector. All results are registered. One cycle after an accepted request the block raises `redirect_o` for a single clock, together with the new PC, the link write and the new status word. The core treats that pulse as its cue to drop its load reservation and clear its per-instruction flags.

Top module: `trap_entry_seq`

## Requirements
- R1: An interrupt is accepted only when status bit 1 (interrupt enable) is 1, status bit 9 (exception active) and status bit 3 (break active) are 0, and neither `flag_dslot_i` nor `flag_imm_i` is set. Otherwise it causes no redirect.
- R2: The new PC is `base_vec_i` + 0x10 for an interrupt, + 0x18 for a break, and + 0x20 for hardware exceptions and translation faults.
- R3: An interrupt writes the PC to link register 14 and clears status bit 1. A break writes the PC to link register 16 and sets status bit 3. Both exception kinds use link register 17 and set status bit 9.
- R4: A hardware exception saves PC+4 in link register 17.
- R5: A translation fault saves one of the following in link register 17: PC-8 when in a delay slot with `flag_bimm_i` set, PC-4 when in any other delay slot, PC-4 after an immediate prefix, and PC otherwise.
- R6: On an exception in a delay slot, syndrome bit 12 is set and `btr_o` captures `btarget_i`. On an exception outside a delay slot, bit 12 is cleared and `btr_o` is kept.
- R7: On every entry, status bits 11 (user) and 13 (translate) are copied into bits 12 and 14 and then cleared. All other status bits not named in R3 pass through unchanged.
- R8: A translation fault writes syndrome code 16 for a data protection fault, 17 for an instruction protection fault, 18 for a data miss and 19 for an instruction miss, in bits 4:0. The access encoding is 0 load, 1 store, 2 fetch; a store also sets bit 10. `ear_o` captures `fault_addr_i`.
- R9: A misaligned hardware exception writes cause 1, ORs in `hwx_syn_i` at bits 11:5 when `hwx_syn_vld_i` is set, and captures `fault_addr_i` in `ear_o`. Any other hardware exception writes `hwx_cause_i` in bits 4:0 and leaves `ear_o` unchanged.
- R10: A hardware exception request while `exc_en_i` is 0 is ignored: there is no redirect, and the syndrome, fault address and branch-target registers stay as they were.
- R11: When several requests arrive together, a translation fault wins over a hardware exception, which wins over a break, which wins over an interrupt.
- R12: `redirect_o` is high for exactly the cycle after each accepted request. Syndrome, fault address and branch target change only on exception entry.
- R13: After reset `redirect_o`, `status_o`, `esr_o`, `ear_o` and `btr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | XLEN | PC of the instruction at trap time |
| status_i | input | XLEN | Current machine status word |
| flag_dslot_i | input | 1 | Instruction sits in a branch delay slot |
| flag_imm_i | input | 1 | Instruction follows an immediate prefix |
| flag_bimm_i | input | 1 | The delay slot's branch carried an immediate prefix |
| btarget_i | input | XLEN | Pending branch target |
| base_vec_i | input | XLEN | Vector table base |
| exc_en_i | input | 1 | Configuration: hardware exceptions enabled |
| irq_i | input | 1 | External interrupt request |
| brk_i | input | 1 | Hardware break request |
| hwx_req_i | input | 1 | Hardware exception request |
| hwx_unal_i | input | 1 | Hardware exception is a misaligned data access |
| hwx_cause_i | input | 5 | Cause code for other hardware exceptions |
| hwx_syn_i | input | SYN_W | Instruction-supplied syndrome bits |
| hwx_syn_vld_i | input | 1 | Syndrome bits are valid |
| mmu_req_i | input | 1 | Translation fault request |
| mmu_miss_i | input | 1 | Fault is a miss (1) or a protection fault (0) |
| mmu_acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| fault_addr_i | input | XLEN | Faulting address |
| redirect_o | output | 1 | One-cycle trap-entry pulse |
| new_pc_o | output | XLEN | Handler vector address |
| link_sel_o | output | 5 | Link register index to write |
| link_data_o | output | XLEN | Return address to write |
| status_o | output | XLEN | Status word to commit |
| esr_o | output | XLEN | Exception syndrome register |
| ear_o | output | XLEN | Exception address register |
| btr_o | output | XLEN | Branch target register |

## Verification
The assertions assume the pipeline never raises `flag_bimm_i` without `flag_dslot_i` and never raises `flag_dslot_i` together with `flag_imm_i`. They also assume `mmu_acc_i` never carries the unused code 3. The stimulus keeps to these rules: the prefixed-branch flag is drawn only when a delay slot is drawn, the immediate flag only when no delay slot is drawn, and the access type only from 0 to 2. The vector and link-register assertions take `base_vec_i` and `pc_i` as free data. No ordering is assumed among simultaneous requests, so the priority cases are driven deliberately.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {TC_NONE, TC_IRQ, TC_BRK, TC_HWX, TC_MMU} trap_cls_e;

  // status word bit positions; saved-mode bits sit one above their live bits
  localparam int unsigned ST_IE  = 1;
  localparam int unsigned ST_BIP = 3;
  localparam int unsigned ST_EIP = 9;
  localparam int unsigned ST_UM  = 11;
  localparam int unsigned ST_VM  = 13;

  // syndrome layout
  localparam int unsigned SY_SYN_LSB = 5;
  localparam int unsigned SY_STORE   = 10;
  localparam int unsigned SY_DS      = 12;

  localparam logic [4:0] EC_UNAL  = 5'd1;
  localparam logic [4:0] EC_DPROT = 5'd16;
  localparam logic [4:0] EC_IPROT = 5'd17;
  localparam logic [4:0] EC_DMISS = 5'd18;
  localparam logic [4:0] EC_IMISS = 5'd19;

  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [4:0] LNK_IRQ = 5'd14;
  localparam logic [4:0] LNK_BRK = 5'd16;
  localparam logic [4:0] LNK_EXC = 5'd17;

  localparam logic [7:0] VOFF_IRQ = 8'h10;
  localparam logic [7:0] VOFF_BRK = 8'h18;
  localparam logic [7:0] VOFF_EXC = 8'h20;
endpackage

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] status_i,
  input  logic            flag_dslot_i,
  input  logic            flag_imm_i,
  input  logic            exc_en_i,
  input  logic            irq_i,
  input  logic            brk_i,
  input  logic            hwx_req_i,
  input  logic            mmu_req_i,
  output trap_cls_e       cls_o
);
  logic irq_ok;

  assign irq_ok = irq_i && status_i[ST_IE] && !status_i[ST_EIP] && !status_i[ST_BIP]
                  && !flag_dslot_i && !flag_imm_i;

  always_comb begin
    if (mmu_req_i)                  cls_o = TC_MMU;
    else if (hwx_req_i && exc_en_i) cls_o = TC_HWX;
    else if (brk_i)                 cls_o = TC_BRK;
    else if (irq_ok)                cls_o = TC_IRQ;
    else                            cls_o = TC_NONE;
  end
endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  trap_cls_e       cls_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] base_vec_i,
  input  logic            flag_dslot_i,
  input  logic            flag_imm_i,
  input  logic            flag_bimm_i,
  output logic [XLEN-1:0] vec_o,
  output logic [4:0]      link_sel_o,
  output logic [XLEN-1:0] link_data_o
);
  localparam logic [XLEN-1:0] STEP  = XLEN'(4);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(8);

  logic [XLEN-1:0] mmu_ret;

  // rewind to the branch (or its prefix) so the slot re-executes with it
  always_comb begin
    if (flag_dslot_i)    mmu_ret = flag_bimm_i ? pc_i - STEP2 : pc_i - STEP;
    else if (flag_imm_i) mmu_ret = pc_i - STEP;
    else                 mmu_ret = pc_i;
  end

  always_comb begin
    unique case (cls_i)
      TC_IRQ: begin
        vec_o = base_vec_i + XLEN'(VOFF_IRQ); link_sel_o = LNK_IRQ; link_data_o = pc_i;
      end
      TC_BRK: begin
        vec_o = base_vec_i + XLEN'(VOFF_BRK); link_sel_o = LNK_BRK; link_data_o = pc_i;
      end
      TC_HWX: begin
        vec_o = base_vec_i + XLEN'(VOFF_EXC); link_sel_o = LNK_EXC; link_data_o = pc_i + STEP;
      end
      TC_MMU: begin
        vec_o = base_vec_i + XLEN'(VOFF_EXC); link_sel_o = LNK_EXC; link_data_o = mmu_ret;
      end
      default: begin
        vec_o = '0; link_sel_o = '0; link_data_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/trap_status_next.sv
module trap_status_next
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  trap_cls_e       cls_i,
  input  logic [XLEN-1:0] status_i,
  output logic [XLEN-1:0] status_o
);
  localparam int unsigned N_MODE = 2;
  localparam int unsigned MODE_POS [N_MODE] = '{ST_UM, ST_VM};

  logic [XLEN-1:0] flagged;

  always_comb begin
    flagged = status_i;
    unique case (cls_i)
      TC_IRQ:         flagged[ST_IE]  = 1'b0;
      TC_BRK:         flagged[ST_BIP] = 1'b1;
      TC_HWX, TC_MMU: flagged[ST_EIP] = 1'b1;
      default: ;
    endcase
  end

  // push live mode bits into their shadows and drop to privileged, untranslated
  always_comb begin
    status_o = flagged;
    for (int i = 0; i < N_MODE; i++) begin
      status_o[MODE_POS[i]+1] = flagged[MODE_POS[i]];
      status_o[MODE_POS[i]]   = 1'b0;
    end
  end
endmodule

// File: rtl/trap_syndrome.sv
module trap_syndrome
  import trap_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned SYN_W = 7
) (
  input  trap_cls_e        cls_i,
  input  logic             flag_dslot_i,
  input  logic             hwx_unal_i,
  input  logic [4:0]       hwx_cause_i,
  input  logic [SYN_W-1:0] hwx_syn_i,
  input  logic             hwx_syn_vld_i,
  input  logic             mmu_miss_i,
  input  logic [1:0]       mmu_acc_i,
  output logic [XLEN-1:0]  esr_o,
  output logic             esr_we_o,
  output logic             ear_we_o,
  output logic             btr_we_o
);
  logic [4:0] mmu_code;

  always_comb begin
    if (mmu_acc_i == ACC_FETCH) mmu_code = mmu_miss_i ? EC_IMISS : EC_IPROT;
    else                        mmu_code = mmu_miss_i ? EC_DMISS : EC_DPROT;
  end

  always_comb begin
    esr_o = '0;
    if (cls_i == TC_MMU) begin
      esr_o[4:0]      = mmu_code;
      esr_o[SY_STORE] = (mmu_acc_i == ACC_STORE);
    end else if (hwx_unal_i) begin
      esr_o[4:0] = EC_UNAL;
      if (hwx_syn_vld_i) esr_o[SY_SYN_LSB +: SYN_W] = hwx_syn_i;
    end else begin
      esr_o[4:0] = hwx_cause_i;
    end
    esr_o[SY_DS] = flag_dslot_i;
  end

  assign esr_we_o = (cls_i == TC_MMU) || (cls_i == TC_HWX);
  assign ear_we_o = (cls_i == TC_MMU) || (cls_i == TC_HWX && hwx_unal_i);
  assign btr_we_o = esr_we_o && flag_dslot_i;
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned SYN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  status_i,
  input  logic             flag_dslot_i,
  input  logic             flag_imm_i,
  input  logic             flag_bimm_i,
  input  logic [XLEN-1:0]  btarget_i,
  input  logic [XLEN-1:0]  base_vec_i,
  input  logic             exc_en_i,
  input  logic             irq_i,
  input  logic             brk_i,
  input  logic             hwx_req_i,
  input  logic             hwx_unal_i,
  input  logic [4:0]       hwx_cause_i,
  input  logic [SYN_W-1:0] hwx_syn_i,
  input  logic             hwx_syn_vld_i,
  input  logic             mmu_req_i,
  input  logic             mmu_miss_i,
  input  logic [1:0]       mmu_acc_i,
  input  logic [XLEN-1:0]  fault_addr_i,
  output logic             redirect_o,
  output logic [XLEN-1:0]  new_pc_o,
  output logic [4:0]       link_sel_o,
  output logic [XLEN-1:0]  link_data_o,
  output logic [XLEN-1:0]  status_o,
  output logic [XLEN-1:0]  esr_o,
  output logic [XLEN-1:0]  ear_o,
  output logic [XLEN-1:0]  btr_o
);
  trap_cls_e       cls;
  logic [XLEN-1:0] vec_d, link_d, status_d, esr_d;
  logic [4:0]      sel_d;
  logic            esr_we, ear_we, btr_we, take;

  trap_select #(.XLEN(XLEN)) u_sel (
    .status_i, .flag_dslot_i, .flag_imm_i, .exc_en_i,
    .irq_i, .brk_i, .hwx_req_i, .mmu_req_i, .cls_o(cls)
  );

  trap_target #(.XLEN(XLEN)) u_tgt (
    .cls_i(cls), .pc_i, .base_vec_i, .flag_dslot_i, .flag_imm_i, .flag_bimm_i,
    .vec_o(vec_d), .link_sel_o(sel_d), .link_data_o(link_d)
  );

  trap_status_next #(.XLEN(XLEN)) u_st (
    .cls_i(cls), .status_i, .status_o(status_d)
  );

  trap_syndrome #(.XLEN(XLEN), .SYN_W(SYN_W)) u_syn (
    .cls_i(cls), .flag_dslot_i, .hwx_unal_i, .hwx_cause_i, .hwx_syn_i, .hwx_syn_vld_i,
    .mmu_miss_i, .mmu_acc_i, .esr_o(esr_d), .esr_we_o(esr_we), .ear_we_o(ear_we),
    .btr_we_o(btr_we)
  );

  assign take = (cls != TC_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o  <= 1'b0;
      new_pc_o    <= '0;
      link_sel_o  <= '0;
      link_data_o <= '0;
      status_o    <= '0;
    end else begin
      redirect_o <= take;
      if (take) begin
        new_pc_o    <= vec_d;
        link_sel_o  <= sel_d;
        link_data_o <= link_d;
        status_o    <= status_d;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esr_o <= '0;
      ear_o <= '0;
      btr_o <= '0;
    end else begin
      if (esr_we) esr_o <= esr_d;
      if (ear_we) ear_o <= fault_addr_i;
      if (btr_we) btr_o <= btarget_i;
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] status_i,
  input logic            flag_dslot_i,
  input logic            flag_imm_i,
  input logic [XLEN-1:0] base_vec_i,
  input logic            exc_en_i,
  input logic            mmu_req_i,
  input logic [XLEN-1:0] fault_addr_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] new_pc_o,
  input logic [4:0]      link_sel_o,
  input logic [XLEN-1:0] status_o,
  input logic [XLEN-1:0] esr_o,
  input logic [XLEN-1:0] ear_o
);
  p_irq_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o && link_sel_o == LNK_IRQ |->
      $past(status_i[ST_IE]) && !$past(status_i[ST_EIP]) && !$past(status_i[ST_BIP])
      && !$past(flag_dslot_i) && !$past(flag_imm_i));

  p_vec_irq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o && link_sel_o == LNK_IRQ |-> new_pc_o == $past(base_vec_i) + XLEN'(VOFF_IRQ));

  p_vec_brk_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o && link_sel_o == LNK_BRK |-> new_pc_o == $past(base_vec_i) + XLEN'(VOFF_BRK));

  p_vec_exc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o && link_sel_o == LNK_EXC |-> new_pc_o == $past(base_vec_i) + XLEN'(VOFF_EXC));

  p_irq_ie_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o && link_sel_o == LNK_IRQ |-> !status_o[ST_IE]);

  p_brk_bip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o && link_sel_o == LNK_BRK |-> status_o[ST_BIP]);

  p_exc_eip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o && link_sel_o == LNK_EXC |-> status_o[ST_EIP]);

  p_mode_push_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> !status_o[ST_UM] && !status_o[ST_VM]
      && status_o[ST_UM+1] == $past(status_i[ST_UM])
      && status_o[ST_VM+1] == $past(status_i[ST_VM]));

  p_mmu_ear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o && $past(mmu_req_i) |-> link_sel_o == LNK_EXC && ear_o == $past(fault_addr_i));

  p_exc_dis_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o && link_sel_o == LNK_EXC && !$past(mmu_req_i) |-> $past(exc_en_i));

  p_esr_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(redirect_o && link_sel_o == LNK_EXC) |-> esr_o == $past(esr_o));
endmodule

bind trap_entry_seq trap_entry_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/trap_entry_seq_tb.sv
`timescale 1ns/1ps
module trap_entry_seq_tb_top;
  localparam int XL = 32;
  localparam int SW = 7;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [XL-1:0] pc_i, status_i, btarget_i, base_vec_i, fault_addr_i;
  logic flag_dslot_i, flag_imm_i, flag_bimm_i, exc_en_i, irq_i, brk_i;
  logic hwx_req_i, hwx_unal_i, hwx_syn_vld_i, mmu_req_i, mmu_miss_i;
  logic [4:0] hwx_cause_i;
  logic [SW-1:0] hwx_syn_i;
  logic [1:0] mmu_acc_i;
  logic redirect_o;
  logic [XL-1:0] new_pc_o, link_data_o, status_o, esr_o, ear_o, btr_o;
  logic [4:0] link_sel_o;

  always #4 clk_i = ~clk_i;

  trap_entry_seq #(.XLEN(XL), .SYN_W(SW)) dut_i (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic          e_red;
  logic [XL-1:0] e_pc, e_link, e_st, e_esr, e_ear, e_btr;
  logic [4:0]    e_sel;
  string         tag, esr_tag;

  task automatic chk(string rq, string fld, logic [XL-1:0] act, logic [XL-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, fld, act, exp);
    end
  endtask

  task automatic idle();
    irq_i = 0; brk_i = 0; hwx_req_i = 0; mmu_req_i = 0;
    flag_dslot_i = 0; flag_imm_i = 0; flag_bimm_i = 0;
    hwx_unal_i = 0; hwx_syn_vld_i = 0; hwx_cause_i = 0; hwx_syn_i = 0;
    mmu_miss_i = 0; mmu_acc_i = 0; exc_en_i = 1;
  endtask

  // behavioural reference: what the outputs must hold after the coming edge
  task automatic model();
    int kind, nreq;
    logic [XL-1:0] m;
    logic um, vm;
    nreq = int'(mmu_req_i) + int'(hwx_req_i && exc_en_i) + int'(brk_i) + int'(irq_i);
    if (mmu_req_i) kind = 4;
    else if (hwx_req_i && exc_en_i) kind = 3;
    else if (brk_i) kind = 2;
    else if (irq_i && status_i[1] && !status_i[9] && !status_i[3] && !flag_dslot_i && !flag_imm_i)
      kind = 1;
    else kind = 0;
    tag = "R12";
    esr_tag = "R12";
    if (hwx_req_i && !exc_en_i && kind == 0) tag = "R10";
    if (irq_i && kind <= 1) tag = "R1";
    e_red = (kind != 0);
    if (kind == 0) return;
    case (kind)
      1: begin e_pc = base_vec_i + 32'h10; e_sel = 14; e_link = pc_i; end
      2: begin e_pc = base_vec_i + 32'h18; e_sel = 16; e_link = pc_i; tag = "R3"; end
      3: begin e_pc = base_vec_i + 32'h20; e_sel = 17; e_link = pc_i + 4;
               tag = hwx_unal_i ? "R9" : "R4"; end
      default: begin
        e_pc = base_vec_i + 32'h20; e_sel = 17; tag = "R5";
        if (flag_dslot_i && flag_bimm_i) e_link = pc_i - 8;
        else if (flag_dslot_i || flag_imm_i) e_link = pc_i - 4;
        else e_link = pc_i;
      end
    endcase
    if (nreq > 1) tag = "R11";
    m = status_i;
    if (kind == 1) m[1] = 1'b0;
    if (kind == 2) m[3] = 1'b1;
    if (kind >= 3) m[9] = 1'b1;
    um = m[11]; vm = m[13];
    m[11] = 0; m[13] = 0; m[12] = um; m[14] = vm;
    e_st = m;
    if (kind >= 3) begin
      if (kind == 4) begin
        if (mmu_acc_i == 2) e_esr = mmu_miss_i ? 19 : 17;
        else e_esr = mmu_miss_i ? 18 : 16;
        if (mmu_acc_i == 1) e_esr = e_esr + 32'h400;
        e_ear = fault_addr_i;
        esr_tag = "R8";
      end else if (hwx_unal_i) begin
        e_esr = 1;
        if (hwx_syn_vld_i) e_esr = e_esr + (32'(hwx_syn_i) * 32);
        e_ear = fault_addr_i;
        esr_tag = "R9";
      end else begin
        e_esr = 32'(hwx_cause_i);
        esr_tag = "R4";
      end
      if (flag_dslot_i) begin
        e_esr = e_esr + 32'h1000;
        e_btr = btarget_i;
      end
    end
  endtask

  task automatic step();
    model();
    @(posedge clk_i);
    @(negedge clk_i);
    chk(tag, "redirect", 32'(redirect_o), 32'(e_red));
    if (e_red) begin
      chk("R2", "new_pc", new_pc_o, e_pc);
      chk(tag, "link_sel", 32'(link_sel_o), 32'(e_sel));
      chk(tag, "link_data", link_data_o, e_link);
      chk("R7", "status", status_o, e_st);
    end
    chk(esr_tag, "esr", esr_o, e_esr);
    chk(esr_tag == "R12" ? "R12" : "R8", "ear", ear_o, e_ear);
    chk("R6", "btr", btr_o, e_btr);
  endtask

  initial begin
    idle();
    pc_i = 32'h1000; status_i = 0; btarget_i = 0; base_vec_i = 0; fault_addr_i = 0;
    e_red = 0; e_pc = 0; e_link = 0; e_st = 0; e_esr = 0; e_ear = 0; e_btr = 0; e_sel = 0;
    repeat (3) @(negedge clk_i);
    // R13 reset state
    chk("R13", "redirect", 32'(redirect_o), 0);
    chk("R13", "status", status_o, 0);
    chk("R13", "esr", esr_o, 0);
    chk("R13", "ear", ear_o, 0);
    chk("R13", "btr", btr_o, 0);
    rst_ni = 1;
    base_vec_i = 32'h0000_8000;
    step();
    // R1 accepted, then R12 single pulse
    irq_i = 1; status_i = 32'h0000_2802; step();
    idle(); step();
    // R1 blocked: enable off, exception active, break active, delay slot, imm prefix
    irq_i = 1; status_i = 32'h0; step();
    status_i = 32'h202; step();
    status_i = 32'h00a; step();
    status_i = 32'h2; flag_dslot_i = 1; step();
    flag_dslot_i = 0; flag_imm_i = 1; step();
    idle();
    // R3 break
    brk_i = 1; pc_i = 32'h2004; status_i = 32'h0000_0802; step();
    idle();
    // R4 plain hardware exception, then in a delay slot (R6)
    hwx_req_i = 1; hwx_cause_i = 5'd7; pc_i = 32'h3000; step();
    flag_dslot_i = 1; btarget_i = 32'hCAFE_0000; hwx_cause_i = 5'd3; step();
    idle();
    // R10 disabled exceptions
    hwx_req_i = 1; exc_en_i = 0; hwx_unal_i = 1; fault_addr_i = 32'hDEAD_0001; step();
    idle();
    // R9 misaligned with and without syndrome
    hwx_req_i = 1; hwx_unal_i = 1; hwx_syn_vld_i = 1; hwx_syn_i = 7'h5A;
    fault_addr_i = 32'h0000_1233; step();
    hwx_syn_vld_i = 0; fault_addr_i = 32'h0000_4441; step();
    idle();
    // R8 / R5 translation faults across codes and return rules
    pc_i = 32'h5000;
    for (int a = 0; a < 3; a++) begin
      for (int mi = 0; mi < 2; mi++) begin
        mmu_req_i = 1; mmu_acc_i = 2'(a); mmu_miss_i = mi[0];
        fault_addr_i = 32'h7000 + 32'(a * 16 + mi); step();
      end
    end
    flag_dslot_i = 1; flag_bimm_i = 1; btarget_i = 32'h0BAD_0040; step();
    flag_bimm_i = 0; step();
    flag_dslot_i = 0; flag_imm_i = 1; step();
    flag_imm_i = 0; step();
    idle();
    // R11 priority
    status_i = 32'h2; irq_i = 1; brk_i = 1; hwx_req_i = 1; mmu_req_i = 1; step();
    mmu_req_i = 0; step();
    hwx_req_i = 0; step();
    idle();
    // random traffic within the flag rules
    for (int n = 0; n < 3000; n++) begin
      irq_i = ($urandom % 3) == 0;
      brk_i = ($urandom % 6) == 0;
      hwx_req_i = ($urandom % 6) == 0;
      mmu_req_i = ($urandom % 6) == 0;
      exc_en_i = ($urandom % 8) != 0;
      status_i = $urandom;
      flag_dslot_i = ($urandom % 3) == 0;
      flag_bimm_i = flag_dslot_i && ($urandom % 2);
      flag_imm_i = !flag_dslot_i && (($urandom % 3) == 0);
      hwx_unal_i = $urandom % 2;
      hwx_cause_i = 5'($urandom);
      hwx_syn_i = 7'($urandom);
      hwx_syn_vld_i = $urandom % 2;
      mmu_miss_i = $urandom % 2;
      mmu_acc_i = 2'($urandom % 3);
      pc_i = $urandom & 32'hFFFF_FFFC;
      btarget_i = $urandom;
      base_vec_i = $urandom & 32'hFFFF_FF00;
      fault_addr_i = $urandom;
      step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule